// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This block is the processor-side half of interrupt handling. It owns the status register, which holds an interrupt-enable bit and the current interrupt level, and it owns the program counter. An interrupt controller offers one maskable request with its level and vector. The block checks that request against the status register every cycle. A non-maskable request comes in on a separate line with its own vector.

When an instruction finishes and a request may be taken, the block runs a fixed entry sequence. It saves the status and the resume address in an internal stack of frames. It then clears the enable bit, raises the level to that of the request, and jumps to the vector. A return command pops the newest frame and restores both the status and the program counter. Handlers can nest if software sets the enable bit again through the status write port. Only requests at a strictly higher level can then interrupt the handler.

Top module: `irq_seq_top`

## Requirements
- R1: After reset the enable bit is 0, the level is 0, the PC equals the `RESET_PC` parameter (0), `ack` is low, `busy` is low and the stack is empty.
- R2: At an instruction boundary (`instr_done` high while not busy, `reti` low), a maskable request is taken only if the enable bit is 1 and `irq_lvl` is strictly greater than the status level. If no request is taken, the PC loads `next_pc`.
- R3: A pending request that is allowed is not taken until `instr_done` is high. While waiting, `ack` and `busy` stay low.
- R4: On a take, `ack` is high for exactly one cycle, in the cycle after the boundary edge, with `ack_vec` set to the vector. The next three edges push {status, resume PC}, then clear the enable bit and set the level, then load the vector into the PC. `busy` is high from the `ack` cycle until the PC holds the vector.
- R5: A rising edge on `nmi` is taken at the next boundary regardless of the enable bit and level, and it wins over a maskable request. It is taken once per rising edge, signals `ack_nmi`=1 and uses `nmi_vec`. It leaves the status level unchanged and clears the enable bit.
- R6: Inside a handler whose enable bit software has set again, a request at the same level is not taken. A request at a higher level nests.
- R7: A return command at a boundary pops the newest frame and restores the status and the PC saved at entry, in last-in first-out order.
- R8: The stack holds `DEPTH` (8) frames. A push when it is full drops the frame, and `stk_ovf` pulses for one cycle in the cycle after the push edge. The entry sequence still completes.
- R9: A return on an empty stack leaves the status unchanged, loads `next_pc` into the PC, and pulses `stk_udf` for one cycle.
- R10: A status write (`sw_wr`) is applied only when the block is not busy and `instr_done` is low. The new enable bit and level appear after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_done | input | 1 | The current instruction completes this cycle |
| next_pc | input | 16 | Address of the next instruction, used as resume address |
| irq_req | input | 1 | Maskable request offered by the controller |
| irq_lvl | input | 3 | Level of the maskable request |
| irq_vec | input | 16 | Handler address of the maskable request |
| nmi | input | 1 | Non-maskable request line (edge-detected) |
| nmi_vec | input | 16 | Handler address for the non-maskable request |
| reti | input | 1 | The completing instruction is a return from interrupt |
| sw_wr | input | 1 | Software write of the status register |
| sw_ie | input | 1 | Enable bit value to write |
| sw_il | input | 3 | Level value to write |
| pc | output | 16 | Program counter |
| st_ie | output | 1 | Status enable bit |
| st_il | output | 3 | Status interrupt level |
| busy | output | 1 | Entry sequence in progress |
| ack | output | 1 | One-cycle acknowledge of a taken request |
| ack_vec | output | 16 | Vector of the taken request |
| ack_nmi | output | 1 | The taken request was non-maskable |
| stk_ovf | output | 1 | Pulse: push attempted on a full stack |
| stk_udf | output | 1 | Pulse: return attempted on an empty stack |

## Verification
The in-line properties check several rules on every cycle. `ack` is a single-cycle pulse, and every maskable grant had the enable bit set and a strictly higher level. Three cycles after an acknowledge, the PC holds the acknowledged vector, and a non-maskable entry leaves the level where it was. The stack count never exceeds its depth and never moves on a refused push. Other behaviour can only be shown by the bench's scenarios. These are the full sweep of enable, level and request level against arithmetic expectations, and correct restoration after nested handlers. They also cover the frame lost on overflow and the one-shot nature of a held non-maskable line.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;

    localparam int LVL_W = 3;
    localparam int PC_W  = 16;

    typedef logic [LVL_W-1:0] lvl_t;
    typedef logic [PC_W-1:0]  pc_t;

    typedef struct packed {
        logic ie;
        lvl_t il;
    } status_t;

    typedef struct packed {
        status_t st;
        pc_t     pc;
    } frame_t;

    typedef struct packed {
        logic is_nmi;
        lvl_t lvl;
        pc_t  vec;
    } grant_t;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_PUSH,
        SQ_STAT,
        SQ_LOAD
    } sq_state_t;

    function automatic logic lvl_above(lvl_t req, lvl_t cur);
        return req > cur;
    endfunction

endpackage

// File: rtl/irq_accept.sv
module irq_accept
    import irq_seq_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  status_t st,
    input  logic    irq_req,
    input  lvl_t    irq_lvl,
    input  pc_t     irq_vec,
    input  logic    nmi,
    input  pc_t     nmi_vec,
    input  logic    consume,
    output logic    want,
    output grant_t  grant
);

    logic nmi_prev;
    logic nmi_pend;
    logic nmi_edge;
    logic nmi_hot;
    logic mi_ok;

    assign nmi_edge = nmi & ~nmi_prev;
    assign nmi_hot  = nmi_pend | nmi_edge;
    assign mi_ok    = irq_req & st.ie & lvl_above(irq_lvl, st.il);
    assign want     = nmi_hot | mi_ok;

    always_comb begin
        if (nmi_hot) begin
            grant.is_nmi = 1'b1;
            grant.lvl    = st.il;
            grant.vec    = nmi_vec;
        end else begin
            grant.is_nmi = 1'b0;
            grant.lvl    = irq_lvl;
            grant.vec    = irq_vec;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            nmi_prev <= 1'b0;
            nmi_pend <= 1'b0;
        end else begin
            nmi_prev <= nmi;
            if (consume && nmi_hot)
                nmi_pend <= 1'b0;
            else if (nmi_edge)
                nmi_pend <= 1'b1;
        end
    end

    // R5
    nmi_once_chk: assert property (@(posedge clk) disable iff (rst)
        (consume && nmi_hot) |=> !nmi_pend);

    // R5
    nmi_first_chk: assert property (@(posedge clk) disable iff (rst)
        (nmi_hot && want) |-> grant.is_nmi);

endmodule

// File: rtl/irq_stack.sv
module irq_stack
    import irq_seq_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   push,
    input  logic   pop,
    input  frame_t wdata,
    output frame_t rdata,
    output logic   full,
    output logic   empty
);

    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    frame_t           mem [DEPTH];
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] top;

    assign full  = (cnt == CNT_W'(DEPTH));
    assign empty = (cnt == '0);
    assign top   = cnt - CNT_W'(1);
    assign rdata = empty ? '0 : mem[top[IDX_W-1:0]];

    always_ff @(posedge clk) begin
        if (push && !full)
            mem[cnt[IDX_W-1:0]] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (push && !full)
            cnt <= cnt + CNT_W'(1);
        else if (pop && !empty)
            cnt <= cnt - CNT_W'(1);
    end

    // R8
    stk_bound_chk: assert property (@(posedge clk) disable iff (rst)
        cnt <= CNT_W'(DEPTH));

    // R8
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        (push && full) |=> (cnt == $past(cnt)));

    // R7
    pop_step_chk: assert property (@(posedge clk) disable iff (rst)
        (pop && !empty) |=> (cnt == $past(cnt) - CNT_W'(1)));

    // R7
    push_pop_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(push && pop));

endmodule

// File: rtl/irq_seq_fsm.sv
module irq_seq_fsm
    import irq_seq_pkg::*;
#(
    parameter logic [PC_W-1:0] RESET_PC = '0
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    instr_done,
    input  pc_t     next_pc,
    input  logic    reti,
    input  logic    sw_wr,
    input  logic    sw_ie,
    input  lvl_t    sw_il,
    input  logic    want,
    input  grant_t  grant,
    input  frame_t  stk_top,
    input  logic    stk_full,
    input  logic    stk_empty,
    output status_t st,
    output pc_t     pc,
    output logic    busy,
    output logic    ack,
    output pc_t     ack_vec,
    output logic    ack_nmi,
    output logic    push,
    output logic    pop,
    output frame_t  push_frame,
    output logic    consume,
    output logic    ovf,
    output logic    udf
);

    sq_state_t state;
    grant_t    g_q;
    logic      boundary;
    logic      do_ret;
    logic      do_take;

    assign boundary   = (state == SQ_IDLE) && instr_done;
    assign do_ret     = boundary && reti;
    assign do_take    = boundary && !reti && want;
    assign consume    = do_take;
    assign push       = (state == SQ_PUSH);
    assign pop        = do_ret && !stk_empty;
    assign push_frame = '{st: st, pc: pc};
    assign busy       = (state != SQ_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= SQ_IDLE;
            st      <= '0;
            pc      <= RESET_PC;
            g_q     <= '0;
            ack     <= 1'b0;
            ack_vec <= '0;
            ack_nmi <= 1'b0;
            ovf     <= 1'b0;
            udf     <= 1'b0;
        end else begin
            ack <= 1'b0;
            ovf <= 1'b0;
            udf <= 1'b0;
            unique case (state)
                SQ_IDLE: begin
                    if (do_ret) begin
                        if (!stk_empty) begin
                            st <= stk_top.st;
                            pc <= stk_top.pc;
                        end else begin
                            udf <= 1'b1;
                            pc  <= next_pc;
                        end
                    end else if (do_take) begin
                        ack     <= 1'b1;
                        ack_vec <= grant.vec;
                        ack_nmi <= grant.is_nmi;
                        g_q     <= grant;
                        pc      <= next_pc;
                        state   <= SQ_PUSH;
                    end else if (instr_done) begin
                        pc <= next_pc;
                    end else if (sw_wr) begin
                        st.ie <= sw_ie;
                        st.il <= sw_il;
                    end
                end
                SQ_PUSH: begin
                    ovf   <= stk_full;
                    state <= SQ_STAT;
                end
                SQ_STAT: begin
                    st.ie <= 1'b0;
                    if (!g_q.is_nmi)
                        st.il <= g_q.lvl;
                    state <= SQ_LOAD;
                end
                SQ_LOAD: begin
                    pc    <= g_q.vec;
                    state <= SQ_IDLE;
                end
                default: state <= SQ_IDLE;
            endcase
        end
    end

    // R4
    ack_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        ack |=> !ack);

    // R4
    entry_vec_chk: assert property (@(posedge clk) disable iff (rst)
        ack |=> ##2 ((pc == $past(ack_vec, 3)) && !busy));

    // R4
    entry_clear_chk: assert property (@(posedge clk) disable iff (rst)
        ack |=> ##1 !st.ie);

    // R2
    mask_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (ack && !ack_nmi) |-> ($past(st.ie) && (g_q.lvl > $past(st.il))));

    // R5
    nmi_level_chk: assert property (@(posedge clk) disable iff (rst)
        (ack && ack_nmi) |=> ##2 (st.il == $past(st.il, 3)));

    // R3
    wait_boundary_chk: assert property (@(posedge clk) disable iff (rst)
        ((state == SQ_IDLE) && !instr_done) |=> !ack);

    // R9
    udf_hold_chk: assert property (@(posedge clk) disable iff (rst)
        udf |-> (st == $past(st)));

endmodule

// File: rtl/irq_seq_top.sv
module irq_seq_top
    import irq_seq_pkg::*;
#(
    parameter int              DEPTH    = 8,
    parameter logic [PC_W-1:0] RESET_PC = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             instr_done,
    input  logic [PC_W-1:0]  next_pc,
    input  logic             irq_req,
    input  logic [LVL_W-1:0] irq_lvl,
    input  logic [PC_W-1:0]  irq_vec,
    input  logic             nmi,
    input  logic [PC_W-1:0]  nmi_vec,
    input  logic             reti,
    input  logic             sw_wr,
    input  logic             sw_ie,
    input  logic [LVL_W-1:0] sw_il,
    output logic [PC_W-1:0]  pc,
    output logic             st_ie,
    output logic [LVL_W-1:0] st_il,
    output logic             busy,
    output logic             ack,
    output logic [PC_W-1:0]  ack_vec,
    output logic             ack_nmi,
    output logic             stk_ovf,
    output logic             stk_udf
);

    status_t st;
    grant_t  grant;
    frame_t  push_frame;
    frame_t  stk_top;
    logic    want;
    logic    consume;
    logic    push;
    logic    pop;
    logic    stk_full;
    logic    stk_empty;

    assign st_ie = st.ie;
    assign st_il = st.il;

    irq_accept u_accept (
        .clk     (clk),
        .rst     (rst),
        .st      (st),
        .irq_req (irq_req),
        .irq_lvl (irq_lvl),
        .irq_vec (irq_vec),
        .nmi     (nmi),
        .nmi_vec (nmi_vec),
        .consume (consume),
        .want    (want),
        .grant   (grant)
    );

    irq_stack #(.DEPTH(DEPTH)) u_stack (
        .clk   (clk),
        .rst   (rst),
        .push  (push),
        .pop   (pop),
        .wdata (push_frame),
        .rdata (stk_top),
        .full  (stk_full),
        .empty (stk_empty)
    );

    irq_seq_fsm #(.RESET_PC(RESET_PC)) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .instr_done (instr_done),
        .next_pc    (next_pc),
        .reti       (reti),
        .sw_wr      (sw_wr),
        .sw_ie      (sw_ie),
        .sw_il      (sw_il),
        .want       (want),
        .grant      (grant),
        .stk_top    (stk_top),
        .stk_full   (stk_full),
        .stk_empty  (stk_empty),
        .st         (st),
        .pc         (pc),
        .busy       (busy),
        .ack        (ack),
        .ack_vec    (ack_vec),
        .ack_nmi    (ack_nmi),
        .push       (push),
        .pop        (pop),
        .push_frame (push_frame),
        .consume    (consume),
        .ovf        (stk_ovf),
        .udf        (stk_udf)
    );

endmodule

// File: tb/sim_irq_seq_top.sv
module sim_irq_seq_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        instr_done;
    logic [15:0] next_pc;
    logic        irq_req;
    logic [2:0]  irq_lvl;
    logic [15:0] irq_vec;
    logic        nmi;
    logic [15:0] nmi_vec;
    logic        reti;
    logic        sw_wr;
    logic        sw_ie;
    logic [2:0]  sw_il;
    logic [15:0] pc;
    logic        st_ie;
    logic [2:0]  st_il;
    logic        busy;
    logic        ack;
    logic [15:0] ack_vec;
    logic        ack_nmi;
    logic        stk_ovf;
    logic        stk_udf;

    int errs   = 0;
    int checks = 0;
    int cycles = 0;
    logic done = 1'b0;

    always #2.5 clk = ~clk;

    irq_seq_top u0 (
        .clk(clk), .rst(rst), .instr_done(instr_done), .next_pc(next_pc),
        .irq_req(irq_req), .irq_lvl(irq_lvl), .irq_vec(irq_vec),
        .nmi(nmi), .nmi_vec(nmi_vec), .reti(reti),
        .sw_wr(sw_wr), .sw_ie(sw_ie), .sw_il(sw_il),
        .pc(pc), .st_ie(st_ie), .st_il(st_il), .busy(busy),
        .ack(ack), .ack_vec(ack_vec), .ack_nmi(ack_nmi),
        .stk_ovf(stk_ovf), .stk_udf(stk_udf)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000 && !done) begin
            errs = errs + 1;
            checks = checks + 1;
            $display("FAIL watchdog: got %0d cycles exp fewer", cycles);
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            errs = errs + 1;
            $display("FAIL %s: got %h exp %h", tag, act, exp);
        end
    endtask

    task automatic tick;
        @(posedge clk);
        #1;
    endtask

    task automatic sw(input logic e, input logic [2:0] l);
        sw_wr = 1'b1; sw_ie = e; sw_il = l;
        tick;
        sw_wr = 1'b0;
    endtask

    task automatic boundary(input logic [15:0] p, input logic r);
        next_pc = p; instr_done = 1'b1; reti = r;
        tick;
        instr_done = 1'b0; reti = 1'b0;
    endtask

    task automatic finish_entry;
        tick; tick; tick;
    endtask

    initial begin
        rst = 1'b1; instr_done = 1'b0; next_pc = '0; irq_req = 1'b0;
        irq_lvl = '0; irq_vec = '0; nmi = 1'b0; nmi_vec = 16'h6000;
        reti = 1'b0; sw_wr = 1'b0; sw_ie = 1'b0; sw_il = '0;
        tick; tick; tick;
        rst = 1'b0;
        tick;
        // R1 reset state
        chk("R1 pc", 32'(pc), 32'h0);
        chk("R1 ie", 32'(st_ie), 32'h0);
        chk("R1 il", 32'(st_il), 32'h0);
        chk("R1 ack", 32'(ack), 32'h0);
        chk("R1 busy", 32'(busy), 32'h0);

        // R2 R4 R7 R10 sweep of enable, level and request level
        for (int e = 0; e < 2; e++) begin
            for (int l = 0; l < 8; l++) begin
                for (int v = 0; v < 8; v++) begin
                    logic [15:0] p;
                    logic [15:0] vec;
                    logic        exp_take;
                    p   = 16'h1000 + 16'((e * 64 + l * 8 + v) * 2);
                    vec = 16'h4000 + 16'(e * 64 + l * 8 + v);
                    sw(e[0], l[2:0]);
                    if (v == 0) begin
                        chk("R10 ie", 32'(st_ie), 32'(e));
                        chk("R10 il", 32'(st_il), 32'(l));
                    end
                    irq_req = 1'b1; irq_lvl = v[2:0]; irq_vec = vec;
                    boundary(p, 1'b0);
                    irq_req = 1'b0;
                    exp_take = (e == 1) && (v > l);
                    chk("R2 take", 32'(ack), 32'(exp_take));
                    if (exp_take) begin
                        chk("R4 ack_vec", 32'(ack_vec), 32'(vec));
                        chk("R4 busy", 32'(busy), 32'h1);
                        finish_entry;
                        chk("R4 pc", 32'(pc), 32'(vec));
                        chk("R4 il", 32'(st_il), 32'(v));
                        chk("R4 ie", 32'(st_ie), 32'h0);
                        chk("R4 idle", 32'(busy), 32'h0);
                        boundary(16'hDEAD, 1'b1);
                        chk("R7 pc", 32'(pc), 32'(p));
                        chk("R7 ie", 32'(st_ie), 32'(e));
                        chk("R7 il", 32'(st_il), 32'(l));
                    end else begin
                        chk("R2 pc", 32'(pc), 32'(p));
                        chk("R2 st", 32'({st_ie, st_il}), 32'(e * 8 + l));
                    end
                end
            end
        end

        // R3 pending request waits for the boundary
        sw(1'b1, 3'd0);
        irq_req = 1'b1; irq_lvl = 3'd4; irq_vec = 16'h5000;
        for (int i = 0; i < 3; i++) begin
            tick;
            chk("R3 no ack", 32'(ack), 32'h0);
            chk("R3 no busy", 32'(busy), 32'h0);
        end
        boundary(16'h1234, 1'b0);
        irq_req = 1'b0;
        chk("R3 ack", 32'(ack), 32'h1);
        finish_entry;
        boundary(16'hBEEF, 1'b1);
        chk("R3 ret", 32'(pc), 32'h1234);

        // R5 NMI ignores mask and level, one take per edge
        sw(1'b0, 3'd7);
        nmi = 1'b1;
        tick;
        boundary(16'h2222, 1'b0);
        chk("R5 ack", 32'(ack), 32'h1);
        chk("R5 ack_nmi", 32'(ack_nmi), 32'h1);
        chk("R5 vec", 32'(ack_vec), 32'h6000);
        finish_entry;
        chk("R5 il kept", 32'(st_il), 32'h7);
        chk("R5 ie", 32'(st_ie), 32'h0);
        chk("R5 pc", 32'(pc), 32'h6000);
        boundary(16'h2300, 1'b0);
        chk("R5 once", 32'(ack), 32'h0);
        chk("R5 once pc", 32'(pc), 32'h2300);
        boundary(16'hAAAA, 1'b1);
        chk("R5 ret pc", 32'(pc), 32'h2222);
        nmi = 1'b0;
        tick;

        // R5 NMI beats a maskable request in the same cycle
        sw(1'b1, 3'd0);
        irq_req = 1'b1; irq_lvl = 3'd6; irq_vec = 16'h5555;
        nmi = 1'b1;
        boundary(16'h3000, 1'b0);
        chk("R5 prio nmi", 32'(ack_nmi), 32'h1);
        chk("R5 prio vec", 32'(ack_vec), 32'h6000);
        finish_entry;
        chk("R5 prio il", 32'(st_il), 32'h0);
        irq_req = 1'b0; nmi = 1'b0;
        boundary(16'hAAAA, 1'b1);
        chk("R5 prio ret", 32'(pc), 32'h3000);
        chk("R5 prio ie", 32'(st_ie), 32'h1);

        // R6 nesting after software re-enable
        sw(1'b1, 3'd0);
        irq_req = 1'b1; irq_lvl = 3'd3; irq_vec = 16'h7000;
        boundary(16'h0100, 1'b0);
        irq_req = 1'b0;
        finish_entry;
        sw(1'b1, 3'd3);
        chk("R6 ie back", 32'(st_ie), 32'h1);
        irq_req = 1'b1; irq_lvl = 3'd3; irq_vec = 16'h7100;
        boundary(16'h7002, 1'b0);
        chk("R6 same lvl", 32'(ack), 32'h0);
        chk("R6 same pc", 32'(pc), 32'h7002);
        irq_lvl = 3'd5; irq_vec = 16'h7200;
        boundary(16'h7004, 1'b0);
        irq_req = 1'b0;
        chk("R6 nest", 32'(ack), 32'h1);
        finish_entry;
        chk("R6 nest il", 32'(st_il), 32'h5);
        chk("R6 nest pc", 32'(pc), 32'h7200);
        boundary(16'hAAAA, 1'b1);
        chk("R6 ret1", 32'({st_ie, st_il, pc}), {12'h0, 1'b1, 3'd3, 16'h7004});
        boundary(16'hAAAA, 1'b1);
        chk("R6 ret2", 32'({st_ie, st_il, pc}), {12'h0, 1'b1, 3'd0, 16'h0100});

        // R8 overflow on the ninth push
        for (int k = 1; k <= 9; k++) begin
            sw(1'b1, 3'd0);
            irq_req = 1'b1; irq_lvl = 3'd1; irq_vec = 16'h8000;
            boundary(16'h2000 + 16'(k), 1'b0);
            irq_req = 1'b0;
            chk("R8 ack", 32'(ack), 32'h1);
            tick;
            chk("R8 ovf", 32'(stk_ovf), 32'(k == 9));
            tick; tick;
            chk("R8 pc", 32'(pc), 32'h8000);
        end
        for (int k = 8; k >= 1; k--) begin
            boundary(16'hFFFF, 1'b1);
            chk("R8 lifo pc", 32'(pc), 32'(16'h2000 + 16'(k)));
            chk("R7 lifo st", 32'({st_ie, st_il}), 32'h8);
        end

        // R9 return with nothing saved
        sw(1'b0, 3'd5);
        boundary(16'h4321, 1'b1);
        chk("R9 udf", 32'(stk_udf), 32'h1);
        chk("R9 pc", 32'(pc), 32'h4321);
        chk("R9 st", 32'({st_ie, st_il}), 32'h5);
        tick;
        chk("R9 udf pulse", 32'(stk_udf), 32'h0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule